// File: doc/BRIEF.md
# Single-to-Double Precision Widener

This block takes a 32-bit single-precision floating-point bit pattern and produces the 64-bit double-precision image of the same value. A floating-point load-single path uses it to place a single operand into a 64-bit register. Every single-precision value can be written exactly as a double, so the block never rounds.

Normal numbers, signed zeros, infinities and NaNs are formatted by copying and padding bits, and their result is ready one cycle after the start strobe. A subnormal single becomes a normal double. The block finds its leading one with a shift loop that moves the fraction left by one position per cycle and lowers the exponent by one for each shift. The caller pulses `start` with the operand and waits for the one-cycle `done` pulse. The result stays on `dp_word` until the next conversion completes.

Top module: `sp2dp_widen`

## Requirements
- R1: The result sign, `dp_word[63]`, always equals the operand sign, `sp_word[31]`.
- R2: For an operand with biased exponent `sp_word[30:23]` in 1..254, the result is {sign, exp+896 as 11 bits, `sp_word[22:0]`, 29 zero bits}. This is the operand's bit 30, then three copies of the inverse of bit 30, then bits 29..0, then 29 zeros.
- R3: For a special operand the result is {sign, 11 bits, operand fraction, 29 zeros}. A special operand has an exponent of 255, or has an exponent of 0 with a fraction of 0. The 11-bit exponent field is all ones for exponent 255 and all zeros for exponent 0.
- R4: For a subnormal operand (exponent 0, nonzero fraction) whose most significant set fraction bit has index k (0..22), the result exponent field is 874+k. The result fraction is the operand fraction with bit k cleared, shifted left by 52-k.
- R5: For a normal or special operand, `done` is high in the cycle after the cycle in which `start` was sampled.
- R6: For a subnormal operand, `done` goes high 1+(23-k) cycles after `start` is sampled, which is between 2 and 24 cycles.
- R7: `done` is high for exactly one cycle per conversion. `dp_word` does not change between completions.
- R8: A `start` pulse that arrives while a subnormal conversion is running is ignored. It causes no completion and does not alter the result in progress.
- R9: While reset is held, `done` is 0 and `dp_word` is 0.
- R10: The single pattern for 5.0 (0x40A00000) converts to 0x4014000000000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe; `sp_word` is sampled with it |
| sp_word | input | 32 | Single-precision operand bits |
| done | output | 1 | One-cycle pulse: `dp_word` holds a new result |
| dp_word | output | 64 | Double-precision result bits |

## Verification
Every one of the 256 exponent values is applied with both signs and with several fractions: zero, the lowest bit alone, the highest bit alone, all ones and an alternating pattern. This shows the normal rebias apart from the two special encodings and from the zero/subnormal split at exponent 0. A second set of operands puts the leading fraction bit at each of the 23 positions, once alone and once followed by all ones below it. This tests every shift count of the normalization loop, and both its latency and the bits it drops. Directed cases cover a start strobe issued during the longest loop, holding of the result between completions, and the 5.0 reference value.

// File: rtl/sp2dp_pkg.sv
package sp2dp_pkg;
  localparam int SP_W       = 32;
  localparam int SP_EXP_W   = 8;
  localparam int SP_FRAC_W  = 23;
  localparam int DP_W       = 64;
  localparam int DP_EXP_W   = 11;
  localparam int DP_FRAC_W  = 52;
  localparam int PAD_W      = DP_FRAC_W - SP_FRAC_W;
  localparam int WORK_W     = DP_FRAC_W + 1;
  localparam int EXPR_W     = DP_EXP_W + 1;
  localparam int DP_BIAS    = 1023;
  localparam int SP_EMIN    = -126;
  localparam int CNT_W      = $clog2(SP_FRAC_W + 1);
  localparam int DN_EXP_MAX = DP_BIAS + SP_EMIN - 1;
  localparam int DN_EXP_MIN = DN_EXP_MAX - SP_FRAC_W + 1;

  typedef enum logic [1:0] {
    CLS_NORM    = 2'd0,
    CLS_SPECIAL = 2'd1,
    CLS_SUBN    = 2'd2
  } sp_class_e;

  // Bit-copy widening for normal and special operands.
  function automatic logic [DP_W-1:0] copy_widen(input logic [SP_W-1:0] w,
                                                 input logic special);
    logic [DP_W-1:0] r;
    logic            fill;
    fill = special ? w[SP_W-2] : ~w[SP_W-2];
    r = {w[SP_W-1], w[SP_W-2], {3{fill}}, w[SP_W-3:0], {PAD_W{1'b0}}};
    return r;
  endfunction

  // Unbiased exponent to the double-precision biased field.
  function automatic logic [DP_EXP_W-1:0] rebias(input logic signed [EXPR_W-1:0] e);
    logic signed [EXPR_W-1:0] t;
    t = e + EXPR_W'(DP_BIAS);
    return t[DP_EXP_W-1:0];
  endfunction
endpackage

// File: rtl/sp2dp_classify.sv
module sp2dp_classify
  import sp2dp_pkg::*;
(
  input  logic [SP_W-1:0] word,
  output sp_class_e       cls
);
  logic [SP_EXP_W-1:0]  exp_f;
  logic [SP_FRAC_W-1:0] frac_f;
  logic                 exp_zero;
  logic                 exp_ones;
  logic                 frac_zero;

  assign exp_f     = word[SP_W-2 -: SP_EXP_W];
  assign frac_f    = word[SP_FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = (exp_f == '1);
  assign frac_zero = (frac_f == '0);

  always_comb begin
    if (exp_zero && !frac_zero)     cls = CLS_SUBN;
    else if (exp_ones || exp_zero)  cls = CLS_SPECIAL;
    else                            cls = CLS_NORM;
  end
endmodule

// File: rtl/sp2dp_fastpath.sv
module sp2dp_fastpath
  import sp2dp_pkg::*;
(
  input  logic [SP_W-1:0] word,
  input  logic            special,
  output logic [DP_W-1:0] dword
);
  assign dword = copy_widen(word, special);
endmodule

// File: rtl/sp2dp_normalize.sv
module sp2dp_normalize
  import sp2dp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 sign_in,
  input  logic [SP_FRAC_W-1:0] frac_in,
  output logic                 busy,
  output logic                 fin,
  output logic [DP_W-1:0]      result
);
  logic [WORK_W-1:0]        work_q, work_nx;
  logic signed [EXPR_W-1:0] exp_q, exp_nx;
  logic                     sign_q;
  logic                     busy_q;
  logic [CNT_W-1:0]         cnt_q;

  assign work_nx = work_q << 1;
  assign exp_nx  = exp_q - EXPR_W'(1);
  assign fin     = busy_q && work_nx[WORK_W-1];
  assign busy    = busy_q;
  assign result  = {sign_q, rebias(exp_nx), work_nx[DP_FRAC_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q <= '0;
      exp_q  <= '0;
      sign_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      work_q <= {1'b0, frac_in, {PAD_W{1'b0}}};
      exp_q  <= EXPR_W'(SP_EMIN);
      sign_q <= sign_in;
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      work_q <= work_nx;
      exp_q  <= exp_nx;
      cnt_q  <= cnt_q + CNT_W'(1);
      if (fin) busy_q <= 1'b0;
    end
  end

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q); // R8
  AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(SP_FRAC_W))); // R6
  AST_EXP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> (exp_q == $past(exp_q) - EXPR_W'(1))); // R4
  AST_LOAD_LEAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !work_q[WORK_W-1]); // R4
  AST_SUBN_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (result[DP_W-2 -: DP_EXP_W] >= DP_EXP_W'(DN_EXP_MIN) &&
             result[DP_W-2 -: DP_EXP_W] <= DP_EXP_W'(DN_EXP_MAX))); // R4
endmodule

// File: rtl/sp2dp_widen.sv
module sp2dp_widen
  import sp2dp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [SP_W-1:0] sp_word,
  output logic            done,
  output logic [DP_W-1:0] dp_word
);
  sp_class_e       cls;
  logic [DP_W-1:0] fast_word;
  logic [DP_W-1:0] norm_res;
  logic            norm_busy;
  logic            norm_fin;
  logic            accept;
  logic            fast_sel;
  logic            norm_load;
  logic            done_q;
  logic [DP_W-1:0] dp_q;

  sp2dp_classify u_cls (
    .word (sp_word),
    .cls  (cls)
  );

  sp2dp_fastpath u_fast (
    .word    (sp_word),
    .special (cls == CLS_SPECIAL),
    .dword   (fast_word)
  );

  assign accept    = start && !norm_busy;
  assign fast_sel  = accept && (cls != CLS_SUBN);
  assign norm_load = accept && (cls == CLS_SUBN);

  sp2dp_normalize u_norm (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (norm_load),
    .sign_in (sp_word[SP_W-1]),
    .frac_in (sp_word[SP_FRAC_W-1:0]),
    .busy    (norm_busy),
    .fin     (norm_fin),
    .result  (norm_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      dp_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (fast_sel) begin
        dp_q   <= fast_word;
        done_q <= 1'b1;
      end else if (norm_fin) begin
        dp_q   <= norm_res;
        done_q <= 1'b1;
      end
    end
  end

  assign done    = done_q;
  assign dp_word = dp_q;

  AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    fast_sel |=> done_q); // R5
  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    fast_sel |=> (dp_q[DP_W-1] == $past(sp_word[SP_W-1]))); // R1
  AST_QUIET_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_busy && !norm_fin) |=> !done_q); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(dp_q)); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (dp_q[PAD_W-1:0] == '0)); // R2
endmodule

// File: tb/sp2dp_widen_tb.sv
module sp2dp_widen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] sp_word;
  logic        done;
  logic [63:0] dp_word;

  int n_vec = 0;
  int n_bad = 0;
  int cyc_total = 0;

  always #5 clk = ~clk;

  sp2dp_widen u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sp_word (sp_word),
    .done    (done),
    .dp_word (dp_word)
  );

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_bad++;
      $display("FAIL R6 watchdog: cycles=%0d expected <= 150000", cyc_total);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic int top_bit(input logic [22:0] f);
    int k = 0;
    for (int i = 0; i < 23; i++) if (f[i]) k = i;
    return k;
  endfunction

  // Value-based model: rebias and renormalize arithmetically.
  function automatic logic [63:0] model(input logic [31:0] w);
    logic [7:0]  e;
    logic [22:0] f;
    logic [51:0] fr;
    int          k;
    e = w[30:23];
    f = w[22:0];
    if (e == 8'hFF) return {w[31], 11'h7FF, f, 29'b0};
    if (e == 8'h00 && f == '0) return {w[31], 63'b0};
    if (e != 8'h00) return {w[31], 11'(int'(e) + 896), f, 29'b0};
    k = top_bit(f);
    fr = 52'(f);
    fr[k] = 1'b0;
    fr = fr << (52 - k);
    return {w[31], 11'(874 + k), fr};
  endfunction

  function automatic int model_lat(input logic [31:0] w);
    if (w[30:23] == 8'h00 && w[22:0] != '0) return 1 + 23 - top_bit(w[22:0]);
    return 1;
  endfunction

  task automatic run_vec(input logic [31:0] w, input string tag);
    int lat;
    logic [63:0] exp_v;
    exp_v = model(w);
    @(negedge clk);
    start = 1'b1;
    sp_word = w;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    n_vec++;
    if (!done || dp_word !== exp_v || lat != model_lat(w)) begin
      n_bad++;
      $display("FAIL %s word=%h got=%h lat=%0d expected=%h lat=%0d",
               tag, w, dp_word, lat, exp_v, model_lat(w));
    end
  endtask

  initial begin
    logic [22:0] fr_set [5];
    logic [63:0] held;
    int lat;
    fr_set[0] = 23'h000000;
    fr_set[1] = 23'h000001;
    fr_set[2] = 23'h400000;
    fr_set[3] = 23'h7FFFFF;
    fr_set[4] = 23'h2AAAAA;
    rst_n = 1'b0;
    start = 1'b0;
    sp_word = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    n_vec++;
    if (done !== 1'b0 || dp_word !== 64'h0) begin
      n_bad++;
      $display("FAIL R9 reset got done=%b word=%h expected done=0 word=0", done, dp_word);
    end
    rst_n = 1'b1;

    // R10: reference value
    run_vec(32'h40A00000, "R10");
    n_vec++;
    if (dp_word !== 64'h4014000000000000) begin
      n_bad++;
      $display("FAIL R10 got=%h expected=4014000000000000", dp_word);
    end

    // R1 R2 R3 R4 R5 R6: every exponent, both signs, several fractions
    for (int e = 0; e < 256; e++)
      for (int fi = 0; fi < 5; fi++)
        for (int s = 0; s < 2; s++)
          run_vec({s[0], e[7:0], fr_set[fi]},
                  (e == 255 || (e == 0 && fi == 0)) ? "R3 R1 R5" :
                  (e == 0) ? "R4 R6 R1" : "R2 R1 R5");

    // R4 R6: every leading-bit position
    for (int k = 0; k < 23; k++) begin
      run_vec({k[0], 8'h00, 23'(1 << k)}, "R4 R6 single");
      run_vec({~k[0], 8'h00, 23'((1 << (k + 1)) - 1)}, "R4 R6 filled");
    end

    // R7: result held, no further pulse
    run_vec(32'hC2F60000, "R2 R7");
    held = dp_word;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      n_vec++;
      if (done !== 1'b0 || dp_word !== held) begin
        n_bad++;
        $display("FAIL R7 hold got done=%b word=%h expected done=0 word=%h", done, dp_word, held);
      end
    end

    // R8: start during the longest loop is ignored
    @(negedge clk);
    start = 1'b1;
    sp_word = 32'h80000001;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    @(negedge clk); lat++;
    start = 1'b1;
    sp_word = 32'h3F800000;
    @(negedge clk); lat++;
    start = 1'b0;
    sp_word = '0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    n_vec++;
    if (!done || lat != 24 || dp_word !== model(32'h80000001)) begin
      n_bad++;
      $display("FAIL R8 got=%h lat=%0d expected=%h lat=24", dp_word, lat, model(32'h80000001));
    end
    held = dp_word;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      n_vec++;
      if (done !== 1'b0 || dp_word !== held) begin
        n_bad++;
        $display("FAIL R8 extra completion done=%b word=%h expected done=0 word=%h", done, dp_word, held);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule